// File: doc/BRIEF.md
# Product-Term Cluster Steering Router

This block routes sixteen product-term cluster sums to sixteen macrocell logic inputs. Each cluster sum belongs to one macrocell slot. A static per-slot steering field sends the cluster to its own macrocell, or forward by one, two or three hops along an expansion chain. The slots form four interleaved chains with a stride of four. Chain k holds slots k, k+4, k+8 and k+12. A step past the last member of a chain wraps around to its first member.

Every cluster lands at exactly one destination. All other destinations get a constant zero from that cluster, so a cluster that leaves its home slot adds nothing there. Clusters that reach the same macrocell are ORed together bit by bit.

For each macrocell the block also reports the largest hop count among the clusters that land on it. A timing model can multiply this count by the expansion delay of one hop. Each macrocell also shows the maximum product-term reach of its chain. The reach values are set by parameters, with defaults of 75, 80, 75 and 70 for chains 0 to 3. The block has no clock and holds no state.

Top module: `pta_cluster_router`

## Requirements
- R1: A cluster on slot n only ever reaches macrocells n mod 4, n mod 4 + 4, n mod 4 + 8 and n mod 4 + 12, which make up its own chain. No bit of it appears at a macrocell of another chain.
- R2: Steering field value s (0 to 3) on slot n delivers that slot's cluster to macrocell (n + 4*s) mod 16. Value 0 keeps the cluster at macrocell n.
- R3: Steering past slots 12 to 15 wraps around. For example, slot 13 with s=1 lands on macrocell 1, and slot 8 with s=3 lands on macrocell 4.
- R4: A macrocell that no cluster is steered to outputs all zeros, even when its own slot's cluster is nonzero.
- R5: When several clusters land on one macrocell, its output is the bitwise OR of those clusters.
- R6: The hop count output of a macrocell equals the largest steering value among the slots that land on it. It is 0 when no slot lands there. It depends only on the steering fields, not on the cluster data.
- R7: The outputs follow the inputs combinationally, in the same time step, without any clock edge.
- R8: The reach output of macrocell m equals the parameter value for chain m mod 4. The defaults are 75, 80, 75 and 70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clu_sum_i | input | NUM_SLOTS x DATA_W | Cluster sum of each slot |
| steer_cfg_i | input | NUM_SLOTS x STEP_W | Forward hop count per slot (0 to 3) |
| mc_in_o | output | NUM_SLOTS x DATA_W | ORed logic input of each macrocell |
| hop_cnt_o | output | NUM_SLOTS x STEP_W | Largest hop count landing on each macrocell |
| reach_o | output | NUM_SLOTS x REACH_W | Product-term reach of the macrocell's chain |

## Verification
The checker assumes that all inputs are fully known two-state values and that every steering field is below the chain length. With four members per chain, each two-bit field meets that bound. It also assumes the checker sees outputs after the combinational paths have settled. The bench drives only complete defined vectors with steering fields drawn from 0 to 3. It changes inputs well away from clock edges and samples a quarter period later. Directed vectors cover each slot and step, wrap cases, collisions and abandoned destinations, and random vectors cover the rest.

// File: rtl/pta_pkg.sv
package pta_pkg;

    localparam int unsigned DEF_SLOTS   = 16;
    localparam int unsigned DEF_CHAINS  = 4;
    localparam int unsigned DEF_DATA_W  = 1;
    localparam int unsigned DEF_REACH_W = 8;

    typedef int unsigned reach_arr_t [DEF_CHAINS];

    localparam reach_arr_t DEF_REACH = '{75, 80, 75, 70};

    // Slot reached from src after a given number of hops of one stride.
    function automatic int unsigned land_slot(int unsigned src, int unsigned hops,
                                              int unsigned stride, int unsigned slots);
        return (src + hops * stride) % slots;
    endfunction

    // Slot that feeds dst when its cluster travels the given number of hops.
    function automatic int unsigned feed_slot(int unsigned dst, int unsigned hops,
                                              int unsigned stride, int unsigned slots);
        return (dst + slots - ((hops * stride) % slots)) % slots;
    endfunction

    function automatic int unsigned step_width(int unsigned chain_len);
        return (chain_len > 1) ? $clog2(chain_len) : 1;
    endfunction

endpackage

// File: rtl/pta_slot_steer.sv
// Decodes one slot's hop field into a one-hot lane set and gates the
// cluster onto the selected lane only; other lanes carry zero.
module pta_slot_steer #(
    parameter int unsigned CHAIN_LEN = 4,
    parameter int unsigned DATA_W    = 1,
    parameter int unsigned STEP_W    = 2
) (
    input  logic [DATA_W-1:0]                  clu_i,
    input  logic [STEP_W-1:0]                  step_i,
    output logic [CHAIN_LEN-1:0]               sel_o,
    output logic [CHAIN_LEN-1:0][DATA_W-1:0]   lane_o
);

    always_comb begin
        for (int j = 0; j < CHAIN_LEN; j++) begin
            sel_o[j]  = (step_i == STEP_W'(j));
            lane_o[j] = (step_i == STEP_W'(j)) ? clu_i : '0;
        end
    end

endmodule

// File: rtl/pta_dest_merge.sv
// ORs every candidate lane arriving at one macrocell and reports the
// longest hop path among the candidates that are selected.
module pta_dest_merge #(
    parameter int unsigned CHAIN_LEN = 4,
    parameter int unsigned DATA_W    = 1,
    parameter int unsigned STEP_W    = 2
) (
    input  logic [CHAIN_LEN-1:0][DATA_W-1:0] cand_i,
    input  logic [CHAIN_LEN-1:0]             act_i,
    output logic [DATA_W-1:0]                mc_o,
    output logic [STEP_W-1:0]                hop_o
);

    always_comb begin
        mc_o  = '0;
        hop_o = '0;
        for (int j = 0; j < CHAIN_LEN; j++) begin
            mc_o = mc_o | cand_i[j];
            if (act_i[j]) begin
                hop_o = STEP_W'(j);
            end
        end
    end

endmodule

// File: rtl/pta_cluster_router.sv
module pta_cluster_router
    import pta_pkg::*;
#(
    parameter int unsigned NUM_SLOTS      = DEF_SLOTS,
    parameter int unsigned CHAIN_CNT      = DEF_CHAINS,
    parameter int unsigned DATA_W         = DEF_DATA_W,
    parameter int unsigned REACH_W        = DEF_REACH_W,
    parameter reach_arr_t  CHAIN_PT_REACH = DEF_REACH,
    localparam int unsigned CHAIN_LEN     = NUM_SLOTS / CHAIN_CNT,
    localparam int unsigned STEP_W        = step_width(CHAIN_LEN)
) (
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  clu_sum_i,
    input  logic [NUM_SLOTS-1:0][STEP_W-1:0]  steer_cfg_i,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  mc_in_o,
    output logic [NUM_SLOTS-1:0][STEP_W-1:0]  hop_cnt_o,
    output logic [NUM_SLOTS-1:0][REACH_W-1:0] reach_o
);

    if (CHAIN_CNT != DEF_CHAINS || (NUM_SLOTS % CHAIN_CNT) != 0) begin : g_bad_cfg
        $error("pta_cluster_router: chain count must match the reach table and divide the slot count");
    end

    // lane[s][j]: cluster of slot s if it travels j hops, else zero
    logic [NUM_SLOTS-1:0][CHAIN_LEN-1:0][DATA_W-1:0] lane;
    logic [NUM_SLOTS-1:0][CHAIN_LEN-1:0]             sel;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_src
        pta_slot_steer #(
            .CHAIN_LEN (CHAIN_LEN),
            .DATA_W    (DATA_W),
            .STEP_W    (STEP_W)
        ) u_steer (
            .clu_i  (clu_sum_i[s]),
            .step_i (steer_cfg_i[s]),
            .sel_o  (sel[s]),
            .lane_o (lane[s])
        );
    end

    for (genvar m = 0; m < NUM_SLOTS; m++) begin : g_dst
        logic [CHAIN_LEN-1:0][DATA_W-1:0] cand;
        logic [CHAIN_LEN-1:0]             act;

        for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_hop
            localparam int unsigned SRC = feed_slot(m, j, CHAIN_CNT, NUM_SLOTS);
            assign cand[j] = lane[SRC][j];
            assign act[j]  = sel[SRC][j];
        end

        pta_dest_merge #(
            .CHAIN_LEN (CHAIN_LEN),
            .DATA_W    (DATA_W),
            .STEP_W    (STEP_W)
        ) u_merge (
            .cand_i (cand),
            .act_i  (act),
            .mc_o   (mc_in_o[m]),
            .hop_o  (hop_cnt_o[m])
        );

        assign reach_o[m] = REACH_W'(CHAIN_PT_REACH[m % CHAIN_CNT]);
    end

endmodule

// File: rtl/pta_router_chk.sv
module pta_router_chk #(
    parameter int unsigned NUM_SLOTS = 16,
    parameter int unsigned CHAIN_CNT = 4,
    parameter int unsigned DATA_W    = 1,
    parameter int unsigned STEP_W    = 2
) (
    input logic [NUM_SLOTS-1:0][DATA_W-1:0] clu_sum_i,
    input logic [NUM_SLOTS-1:0][STEP_W-1:0] steer_cfg_i,
    input logic [NUM_SLOTS-1:0][DATA_W-1:0] mc_in_o,
    input logic [NUM_SLOTS-1:0][STEP_W-1:0] hop_cnt_o
);

    logic [NUM_SLOTS-1:0]                fed;
    logic [CHAIN_CNT-1:0][DATA_W-1:0]    chain_in;
    logic [CHAIN_CNT-1:0][DATA_W-1:0]    chain_out;

    always_comb begin
        fed       = '0;
        chain_in  = '0;
        chain_out = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            fed[(s + int'(steer_cfg_i[s]) * CHAIN_CNT) % NUM_SLOTS] = 1'b1;
            chain_in[s % CHAIN_CNT]  = chain_in[s % CHAIN_CNT]  | clu_sum_i[s];
            chain_out[s % CHAIN_CNT] = chain_out[s % CHAIN_CNT] | mc_in_o[s];
        end
    end

    always_comb begin
        for (int m = 0; m < NUM_SLOTS; m++) begin
            p_unfed_zero_r4: assert (fed[m] || mc_in_o[m] == '0)
                else $error("unfed macrocell %0d not zero", m);
            p_hop_source_r6: assert (hop_cnt_o[m] == '0 ||
                steer_cfg_i[(m + NUM_SLOTS - (int'(hop_cnt_o[m]) * CHAIN_CNT) % NUM_SLOTS) % NUM_SLOTS]
                    == hop_cnt_o[m])
                else $error("hop count of macrocell %0d has no source", m);
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (steer_cfg_i[s] == '0) begin
                p_home_keep_r2: assert ((mc_in_o[s] & clu_sum_i[s]) == clu_sum_i[s])
                    else $error("slot %0d cluster missing at home", s);
            end
            if (steer_cfg_i[s] != '0 && (s + int'(steer_cfg_i[s]) * CHAIN_CNT) >= NUM_SLOTS) begin
                p_wrap_land_r3: assert ((mc_in_o[(s + int'(steer_cfg_i[s]) * CHAIN_CNT) % NUM_SLOTS]
                                         & clu_sum_i[s]) == clu_sum_i[s])
                    else $error("wrapped cluster of slot %0d lost", s);
            end
        end
        for (int k = 0; k < CHAIN_CNT; k++) begin
            p_chain_isolation_r1: assert ((chain_out[k] & ~chain_in[k]) == '0)
                else $error("chain %0d output has foreign bits", k);
        end
    end

endmodule

bind pta_cluster_router pta_router_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CHAIN_CNT (CHAIN_CNT),
    .DATA_W    (DATA_W),
    .STEP_W    (STEP_W)
) u_chk (
    .clu_sum_i   (clu_sum_i),
    .steer_cfg_i (steer_cfg_i),
    .mc_in_o     (mc_in_o),
    .hop_cnt_o   (hop_cnt_o)
);

// File: tb/pta_cluster_router_tb_top.sv
module pta_cluster_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int DW = 4;
    localparam int SW = 2;
    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [NS-1:0][DW-1:0] clu;
    logic [NS-1:0][SW-1:0] cfg;
    logic [NS-1:0][DW-1:0] mc;
    logic [NS-1:0][SW-1:0] hop;
    logic [NS-1:0][RW-1:0] reach;

    always #(CLK_PERIOD/2) clk = ~clk;

    pta_cluster_router #(
        .DATA_W  (DW),
        .REACH_W (RW)
    ) dut_i (
        .clu_sum_i   (clu),
        .steer_cfg_i (cfg),
        .mc_in_o     (mc),
        .hop_cnt_o   (hop),
        .reach_o     (reach)
    );

    function automatic int exp_reach(int m);
        case (m % 4)
            0:       return 75;
            1:       return 80;
            2:       return 75;
            default: return 70;
        endcase
    endfunction

    task automatic chk(string rq, string what, int m, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s mc%0d actual=%0h expected=%0h", rq, what, m, act, exp);
        end
    endtask

    // Reference: each slot lands at (s + 4*step) mod 16; OR data, max hop.
    task automatic check_all(string rq_data, string rq_hop);
        logic [NS-1:0][DW-1:0] e_mc;
        logic [NS-1:0][SW-1:0] e_hop;
        e_mc  = '0;
        e_hop = '0;
        for (int s = 0; s < NS; s++) begin
            int d;
            d = (s + 4 * int'(cfg[s])) % NS;
            e_mc[d] = e_mc[d] | clu[s];
            if (cfg[s] > e_hop[d]) e_hop[d] = cfg[s];
        end
        for (int m = 0; m < NS; m++) begin
            chk(rq_data, "data", m, int'(mc[m]), int'(e_mc[m]));
            chk(rq_hop, "hop", m, int'(hop[m]), int'(e_hop[m]));
        end
    endtask

    task automatic apply(logic [NS-1:0][DW-1:0] d, logic [NS-1:0][SW-1:0] c);
        @(negedge clk);
        clu = d;
        cfg = c;
        #(CLK_PERIOD/4);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [NS-1:0][DW-1:0] d;
        logic [NS-1:0][SW-1:0] c;
        clu = '0;
        cfg = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset / idle state: all zero in, all zero out; reach per chain (R8)
        apply('0, '0);
        check_all("R4", "R6");
        for (int m = 0; m < NS; m++) chk("R8", "reach", m, int'(reach[m]), exp_reach(m));

        // Single-slot sweep of every slot and step (R2, wrap cases R3)
        for (int s = 0; s < NS; s++) begin
            for (int st = 0; st < 4; st++) begin
                d = '0;
                c = '0;
                d[s] = DW'(s % 15 + 1);
                c[s] = SW'(st);
                apply(d, c);
                check_all((s + 4 * st >= NS) ? "R3" : "R2", "R6");
                if (st != 0)
                    chk("R4", "home", s, int'(mc[s]), 0);
            end
        end

        // Explicit wrap examples (R3): slot 13 s=1 -> mc1, slot 8 s=3 -> mc4
        d = '0; c = '0;
        d[13] = 4'h9; c[13] = 2'd1;
        d[8]  = 4'h6; c[8]  = 2'd3;
        apply(d, c);
        chk("R3", "wrap13", 1, int'(mc[1]), 9);
        chk("R3", "wrap8", 4, int'(mc[4]), 6);

        // Abandoned destination (R4): slot 0 steered to 4, others home
        d = '1; c = '0;
        c[0] = 2'd1;
        apply(d, c);
        chk("R4", "abandon", 0, int'(mc[0]), 0);
        chk("R6", "hop", 4, int'(hop[4]), 1);
        check_all("R4", "R6");

        // Four-way collision in chain 1 onto macrocell 1 (R5, R6)
        d = '0; c = '0;
        d[1] = 4'h1; d[13] = 4'h2; d[9] = 4'h4; d[5] = 4'h8;
        c[13] = 2'd1; c[9] = 2'd2; c[5] = 2'd3;
        apply(d, c);
        chk("R5", "merge", 1, int'(mc[1]), 15);
        chk("R6", "hop", 1, int'(hop[1]), 3);
        chk("R4", "empty", 5, int'(mc[5]), 0);

        // Hop count independent of data (R6): same steering, zero data
        apply('0, c);
        chk("R6", "hop_nodata", 1, int'(hop[1]), 3);

        // Chain isolation: only one chain carries data (R1)
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 50; r++) begin
                d = '0;
                for (int s = k; s < NS; s += 4) d[s] = DW'($urandom);
                c = {$urandom};
                apply(d, c);
                check_all("R1", "R6");
            end
        end

        // Combinational response without a clock edge (R7)
        @(posedge clk);
        #2;
        d = '0; c = '0;
        d[6] = 4'hA; c[6] = 2'd2;
        clu = d; cfg = c;
        #1;
        chk("R7", "nocycle", 14, int'(mc[14]), 10);
        clu[6] = 4'h5;
        #1;
        chk("R7", "nocycle2", 14, int'(mc[14]), 5);

        // Random steering and data, including wraps and collisions (R2, R5, R6)
        for (int r = 0; r < 2000; r++) begin
            d = {$urandom, $urandom};
            c = {$urandom};
            apply(d, c);
            check_all("R5", "R6");
        end

        done = 1'b1;
        finish_run();
    end

endmodule